// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two component predictors that work independently of each other. The first is a per-branch table indexed by the branch address alone. The second is a table indexed by the branch address mixed with a shift register that records the outcomes of recent fetch groups. A third table, also indexed by the branch address, learns per branch which of the two components has been right more often. It settles the final answer whenever the two components disagree.

A front end presents a branch address on the lookup port and receives the final decision one cycle later. Alongside that decision it receives both component guesses and the history value used. It keeps these until the branch resolves. It then returns them with the real outcome on the update port, so that the same global-table entry is trained. Once per completed fetch group, the front end also shifts one bit into the history register: 1 if the group held a taken branch.

All three tables hold 2-bit saturating counters and have 2^IDX_W entries each. The address bits used as the index start above the two word-offset bits.

Top module: `tp_predictor`

## Requirements
- R1: After reset, every counter in the local and global tables reads 1 (weakly not taken) and every selector counter reads 1 (weakly prefer local). The history register is 0. pred_valid is 0, and lookups predict not taken until training changes an entry.
- R2: A lookup presented with lookup_valid high gives its result on the outputs in the next cycle, with pred_valid high in exactly that cycle. A cycle without a lookup leaves pred_valid low in the cycle that follows.
- R3: The local and selector index is lookup_addr[IDX_W+1:2], so addresses that differ only in bits 1:0 or above bit IDX_W+1 share an entry. A component counter predicts taken when its value is 2 or 3.
- R4: The global index is the local index XOR the history register, zero-extended to IDX_W bits.
- R5: When hist_shift is high, the history shifts left by one and hist_taken enters bit 0. The oldest bit is dropped. When hist_shift is low, the history is unchanged. A lookup in the same cycle as a shift sees the history from before the shift.
- R6: If the local and global guesses agree, pred_taken equals them. If they disagree, pred_taken follows the global guess when the selector counter is 2 or 3, and the local guess otherwise.
- R7: An update moves the local counter at the update address and the global counter at (address index XOR upd_hist) one step toward upd_taken. Each counter saturates at 0 and 3.
- R8: The selector counter at the update address moves only when upd_local differs from upd_global. It moves up when upd_global equals upd_taken and down otherwise, saturating at 0 and 3.
- R9: A lookup and an update to the same entry in the same cycle return the counter value from before that update.
- R10: pred_hist returns the history value that was used to form the global index of the lookup being reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_addr | input | ADDR_W | Branch address to predict |
| pred_valid | output | 1 | Prediction outputs hold a fresh result |
| pred_taken | output | 1 | Final taken decision |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| pred_hist | output | HIST_W | History used for the reported lookup |
| upd_valid | input | 1 | Resolved branch update this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_local | input | 1 | Local guess captured at lookup |
| upd_global | input | 1 | Global guess captured at lookup |
| upd_hist | input | HIST_W | History captured at lookup |
| hist_shift | input | 1 | A fetch group completed this cycle |
| hist_taken | input | 1 | That group contained a taken branch |

## Verification
The properties hold for any values on the update port. They take for granted only that reset is held for at least one clock and that all inputs are known values at every rising edge. The bench drives every input on the falling edge and keeps all of them at 0 during reset. In its random phase it feeds arbitrary update guesses and histories, so the selector is trained even by update tuples that no real lookup produced. The directed phases instead return the guesses the reference model predicted, which matches how a real front end uses the block.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_LO = 2'b01;

  // one saturating step toward the given direction
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  // upper half of the counter range means taken / prefer global
  function automatic logic ctr_hi(input ctr_t c);
    return c[1];
  endfunction

  function automatic logic pick(input logic loc, input logic glb, input logic use_glb);
    if (loc == glb) return loc;
    return use_glb ? glb : loc;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int   IDX_W = 11,
  parameter ctr_t INIT  = CTR_WEAK_LO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t wr_next;

  assign wr_next = ctr_step(mem[wr_idx], wr_up);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_q <= INIT;
    end else begin
      if (rd_en) rd_q <= mem[rd_idx];
      if (wr_en) mem[wr_idx] <= wr_next;
    end
  end
endmodule

// File: rtl/tp_hist_reg.sv
module tp_hist_reg #(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)        hist <= '0;
    else if (shift) hist <= {hist[HIST_W-2:0], bit_in};
  end
endmodule

// File: rtl/tp_predictor.sv
module tp_predictor
  import tp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 11,
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_local,
  output logic              pred_global,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic              upd_local,
  input  logic              upd_global,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              hist_shift,
  input  logic              hist_taken
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  ghr_ext, uhist_ext;
  logic [IDX_W-1:0]  lk_lidx, lk_gidx, up_lidx, up_gidx;
  logic              sel_we, sel_up;
  ctr_t              loc_q, glb_q, sel_q;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^{lookup_addr[IDX_LO-1:0], lookup_addr[ADDR_W-1:IDX_HI+1],
                              upd_addr[IDX_LO-1:0], upd_addr[ADDR_W-1:IDX_HI+1]};

  generate
    if (HIST_W < IDX_W) begin : g_pad
      assign ghr_ext   = {{(IDX_W-HIST_W){1'b0}}, ghr};
      assign uhist_ext = {{(IDX_W-HIST_W){1'b0}}, upd_hist};
    end else begin : g_flat
      assign ghr_ext   = ghr;
      assign uhist_ext = upd_hist;
    end
  endgenerate

  assign lk_lidx = lookup_addr[IDX_HI:IDX_LO];
  assign lk_gidx = lk_lidx ^ ghr_ext;
  assign up_lidx = upd_addr[IDX_HI:IDX_LO];
  assign up_gidx = up_lidx ^ uhist_ext;

  // selector learns only from disagreements
  assign sel_we = upd_valid && (upd_local != upd_global);
  assign sel_up = (upd_global == upd_taken);

  tp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift(hist_shift), .bit_in(hist_taken), .hist(ghr)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_LO)) u_local (
    .clk(clk), .rst(rst),
    .rd_en(lookup_valid), .rd_idx(lk_lidx), .rd_q(loc_q),
    .wr_en(upd_valid), .wr_idx(up_lidx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_LO)) u_global (
    .clk(clk), .rst(rst),
    .rd_en(lookup_valid), .rd_idx(lk_gidx), .rd_q(glb_q),
    .wr_en(upd_valid), .wr_idx(up_gidx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_LO)) u_select (
    .clk(clk), .rst(rst),
    .rd_en(lookup_valid), .rd_idx(lk_lidx), .rd_q(sel_q),
    .wr_en(sel_we), .wr_idx(up_lidx), .wr_up(sel_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= lookup_valid;
      if (lookup_valid) pred_hist <= ghr;
    end
  end

  assign pred_local  = ctr_hi(loc_q);
  assign pred_global = ctr_hi(glb_q);
  assign pred_taken  = pick(pred_local, pred_global, ctr_hi(sel_q));
endmodule

// File: rtl/tp_predictor_chk.sv
module tp_predictor_chk #(
  parameter int HIST_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              lookup_valid,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              pred_local,
  input logic              pred_global,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_local,
  input logic              upd_global,
  input logic              hist_shift,
  input logic              hist_taken,
  input logic [HIST_W-1:0] ghr,
  input logic              sel_we
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> pred_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !pred_valid);

  a_r6_agree_passes: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && (pred_local == pred_global)) |-> (pred_taken == pred_local));

  a_r6_result_is_a_component: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> ((pred_taken == pred_local) || (pred_taken == pred_global)));

  a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
    hist_shift |=> (ghr[0] == $past(hist_taken)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !hist_shift |=> $stable(ghr));

  a_r8_sel_gate: assert property (@(posedge clk) disable iff (rst)
    sel_we |-> (upd_valid && (upd_local != upd_global)));

  a_r10_hist_capture: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> (pred_hist == $past(ghr)));
endmodule

bind tp_predictor tp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .lookup_valid(lookup_valid),
  .pred_valid(pred_valid), .pred_taken(pred_taken),
  .pred_local(pred_local), .pred_global(pred_global), .pred_hist(pred_hist),
  .upd_valid(upd_valid), .upd_local(upd_local), .upd_global(upd_global),
  .hist_shift(hist_shift), .hist_taken(hist_taken),
  .ghr(ghr), .sel_we(sel_we)
);

// File: tb/tp_predictor_bench.sv
module tp_predictor_bench;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 11;
  localparam int HIST_W = 11;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              lookup_valid;
  logic [ADDR_W-1:0] lookup_addr;
  logic              pred_valid, pred_taken, pred_local, pred_global;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid, upd_taken, upd_local, upd_global;
  logic [ADDR_W-1:0] upd_addr;
  logic [HIST_W-1:0] upd_hist;
  logic              hist_shift, hist_taken;

  always #5 clk = ~clk;

  tp_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_tp_predictor (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .upd_local(upd_local), .upd_global(upd_global), .upd_hist(upd_hist),
    .hist_shift(hist_shift), .hist_taken(hist_taken)
  );

  // behavioural reference state
  int  m_loc [DEPTH];
  int  m_glb [DEPTH];
  int  m_sel [DEPTH];
  int  m_hist;
  bit  e_valid, e_taken, e_loc, e_glb;
  int  e_hist;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > 3) return 3;
    return v;
  endfunction

  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return (a / 4) % DEPTH;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_loc[i] = 1; m_glb[i] = 1; m_sel[i] = 1;
    end
    m_hist = 0;
    e_valid = 0; e_taken = 0; e_loc = 0; e_glb = 0; e_hist = 0;
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input bit lv, input logic [ADDR_W-1:0] la,
                      input bit uv, input logic [ADDR_W-1:0] ua, input bit ut,
                      input bit ul, input bit ug, input int uh,
                      input bit hs, input bit hb, input string tag);
    int li, gi, ui, ugi;
    lookup_valid = lv; lookup_addr = la;
    upd_valid = uv; upd_addr = ua; upd_taken = ut;
    upd_local = ul; upd_global = ug; upd_hist = uh[HIST_W-1:0];
    hist_shift = hs; hist_taken = hb;
    e_valid = lv;
    if (lv) begin
      li = idx_of(la);
      gi = li ^ m_hist;
      e_loc  = (m_loc[li] >= 2);
      e_glb  = (m_glb[gi] >= 2);
      e_hist = m_hist;
      if (e_loc == e_glb) e_taken = e_loc;
      else                e_taken = (m_sel[li] >= 2) ? e_glb : e_loc;
    end
    if (uv) begin
      ui  = idx_of(ua);
      ugi = ui ^ (uh % (1 << HIST_W));
      m_loc[ui]  = sat(m_loc[ui]  + (ut ? 1 : -1));
      m_glb[ugi] = sat(m_glb[ugi] + (ut ? 1 : -1));
      if (ul != ug) m_sel[ui] = sat(m_sel[ui] + ((ug == ut) ? 1 : -1));
    end
    if (hs) m_hist = ((m_hist << 1) | int'(hb)) % (1 << HIST_W);
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 32'(pred_valid), 32'(e_valid));
    if (e_valid) begin
      check({tag, " taken"},  32'(pred_taken),  32'(e_taken));
      check({tag, " local"},  32'(pred_local),  32'(e_loc));
      check({tag, " global"}, 32'(pred_global), 32'(e_glb));
      check({tag, " hist"},   32'(pred_hist),   32'(e_hist));
    end
  endtask

  task automatic idle(input string tag);
    step(0, '0, 0, '0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input string tag);
    step(1, a, 0, '0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // lookup then resolve with the guesses that lookup produced
  task automatic train(input logic [ADDR_W-1:0] a, input bit t, input string tag);
    look(a, tag);
    step(0, '0, 1, a, t, e_loc, e_glb, e_hist, 0, 0, tag);
  endtask

  task automatic shift(input bit b, input string tag);
    step(0, '0, 0, '0, 0, 0, 0, 0, 1, b, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1;
    lookup_valid = 0; lookup_addr = '0;
    upd_valid = 0; upd_addr = '0; upd_taken = 0;
    upd_local = 0; upd_global = 0; upd_hist = '0;
    hist_shift = 0; hist_taken = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 valid after reset", 32'(pred_valid), 32'd0);
    check("R1 taken after reset", 32'(pred_taken), 32'd0);
    look(32'h0000_0040, "R1 R2 fresh lookup");
    look(32'h0000_1ffc, "R1 fresh lookup");
    idle("R2 valid drops");

    // R3 R7: local training and saturation
    for (int i = 0; i < 5; i++) train(32'h0000_0100, 1, "R7 train up");
    look(32'h0000_0100, "R3 R7 trained taken");
    look(32'h0000_0103, "R3 low bits ignored");
    look(32'h0000_0100 + (32'h1 << (IDX_W + 2)), "R3 high bits alias");
    train(32'h0000_0100, 0, "R7 one miss");
    look(32'h0000_0100, "R7 saturated stays taken");
    train(32'h0000_0100, 0, "R7 second miss");
    look(32'h0000_0100, "R7 falls to not taken");

    // R4 R5 R10: history and global index
    shift(1, "R5 shift one");
    shift(0, "R5 shift zero");
    shift(1, "R5 shift one");
    look(32'h0000_0100, "R4 R10 history mixes index");
    step(1, 32'h0000_0200, 0, '0, 0, 0, 0, 0, 1, 1, "R5 R10 lookup sees old history");
    look(32'h0000_0200, "R5 R10 after shift");
    for (int i = 0; i < 13; i++) shift(i[0], "R5 drop oldest");
    look(32'h0000_0300, "R5 R10 full history");

    // R6 R8: build a disagreement and train the selector
    for (int i = 0; i < HIST_W; i++) shift(0, "R5 clear history");
    for (int i = 0; i < 3; i++) train(32'h0000_0500, 1, "R7 agree train");
    shift(1, "R5 set history");
    look(32'h0000_0500, "R6 disagree prefer local");
    train(32'h0000_0500, 0, "R8 global right");
    train(32'h0000_0500, 0, "R8 global right again");
    look(32'h0000_0500, "R6 R8 selector follows global");
    step(0, '0, 1, 32'h0000_0500, 1, 1, 1, 1, 0, 0, "R8 agree no move");
    look(32'h0000_0500, "R8 selector unchanged");

    // R9: same-cycle lookup and update
    step(1, 32'h0000_0700, 1, 32'h0000_0700, 1, 0, 0, e_hist, 0, 0, "R9 old value");
    look(32'h0000_0700, "R9 write landed");

    // mixed random traffic on a small address set
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ra, rb;
      ra = {$urandom_range(0, 15), 2'b00} << 2;
      rb = {$urandom_range(0, 15), 2'b00} << 2;
      step(bit'($urandom_range(0, 1)), ra,
           bit'($urandom_range(0, 1)), rb, bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           "R6 R7 R8 R9 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule